// File: doc/BRIEF.md
# Dual-Mode Operand Feeder for a Compute Array

The feeder stands between the on-chip operand buffers and a processing-element array. It lets the same array take either dense tiles or pruned, sparse work, and nothing upstream has to reorder or repack the data. In dense mode a whole vector of lane operands arrives in one beat. Lane `i` leaves the feeder `i` cycles later, so the operands reach the array as the skewed wavefront that a systolic array expects, whether it holds weights or outputs stationary.

In sparse mode an upstream selector, such as a top-k pruning stage, pushes index pairs into a small on-chip queue. An address generator turns the pair at the head of the queue into two buffer read addresses, each a programmable base plus the index. The two buffers answer one cycle later. The feeder re-times the indices and the last flag by one register stage so that they line up with the returned data, and presents only active pairs to the array, one per cycle, with no gaps while the queue holds entries. The queue push port is valid/ready: a push is taken on a clock edge where `iq_valid` and `iq_ready` are both high. `iq_ready` falls only when the queue is full. The dense input is also valid/ready, and `dn_ready` is high exactly in dense mode. The array side carries valid flags only, and the array must take every beat that is presented.

Top module: `operand_feeder`

## Requirements
- R1: During and right after reset, `sk_valid` and `sp_valid` are 0 and `iq_ready` is 1 (queue empty).
- R2: In dense mode (`mode`=0), a beat accepted on `dn_data` appears on lane `i` of `sk_valid`/`sk_data` (lane `i` occupies bits `i*DW +: DW`) exactly `i` cycles later. Lane 0 is combinational from the input.
- R3: `dn_ready` is 1 exactly when `mode`=0. Dense beats offered in sparse mode (`mode`=1) are ignored, and no `sk_valid` bit rises from them.
- R4: The index queue holds `QDEPTH` entries. `iq_ready` is 0 exactly when it is full, and a push while full is dropped.
- R5: In sparse mode with the queue non-empty, `ra_en` and `rb_en` are 1, `ra_addr` = (`a_base` + head a-index) mod 2^AW and `rb_addr` = (`b_base` + head b-index) mod 2^AW, and the head is popped. Pops follow push order.
- R6: One cycle after a read is issued, `sp_valid` is 1, `sp_a`/`sp_b` carry the buffer read data, and `sp_aidx`/`sp_bidx` carry the indices of that pair.
- R7: With no read issued in the previous cycle (queue empty or dense mode), `sp_valid` is 0 and `sp_a`, `sp_b`, `sp_aidx`, `sp_bidx` and `sp_last` are all 0.
- R8: The last flag pushed with a pair comes out on `sp_last` with that pair's data.
- R9: In dense mode queued entries are held, not issued, and they are issued in order once the mode becomes sparse.
- R10: A queue holding N entries when sparse mode starts produces N consecutive valid beats with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = dense skew, 1 = sparse gather |
| dn_valid | input | 1 | Dense beat valid |
| dn_ready | output | 1 | Dense beat accepted (dense mode) |
| dn_data | input | LANES*DW | Dense operand vector, lane i at bits i*DW |
| sk_valid | output | LANES | Per-lane valid of the skewed wavefront |
| sk_data | output | LANES*DW | Skewed lane operands |
| iq_valid | input | 1 | Index pair push valid |
| iq_ready | output | 1 | Queue can accept a push |
| iq_aidx | input | AW | Index into buffer A |
| iq_bidx | input | AW | Index into buffer B |
| iq_last | input | 1 | Pair closes an accumulation |
| a_base | input | AW | Base address of buffer A region |
| b_base | input | AW | Base address of buffer B region |
| ra_en | output | 1 | Buffer A read enable |
| ra_addr | output | AW | Buffer A read address |
| ra_data | input | DW | Buffer A data, one cycle after ra_en |
| rb_en | output | 1 | Buffer B read enable |
| rb_addr | output | AW | Buffer B read address |
| rb_data | input | DW | Buffer B data, one cycle after rb_en |
| sp_valid | output | 1 | Gathered pair valid |
| sp_a | output | DW | Gathered operand A |
| sp_b | output | DW | Gathered operand B |
| sp_aidx | output | AW | Index of operand A |
| sp_bidx | output | AW | Index of operand B |
| sp_last | output | 1 | Final pair of an accumulation |

## Verification
Each result has a fixed distance from its cause. Lane `i` of the wavefront trails the accepted beat by `i` cycles. A read is issued in the cycle after the push edge that queued it, its pair is valid one cycle after the read, and `iq_ready` follows a push or pop on the next edge. The bench updates a behavioural model (a queue of pairs, a history of dense vectors and a model of the buffer memories) at each falling edge for the rising edge that has just passed. It then compares every output against that model while the inputs are still held, and new stimulus is applied only two time units later. Directed phases cover full-queue drops, entries held in dense mode, an uninterrupted burst, address wrap-around and dense beats offered in sparse mode.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  typedef enum logic {
    FEED_DENSE  = 1'b0,
    FEED_SPARSE = 1'b1
  } feed_mode_e;
endpackage

// File: rtl/fd_skew_lane.sv
module fd_skew_lane #(
  parameter int DW    = 8,
  parameter int DEPTH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_pipe
      logic [DEPTH-1:0] v_q;
      logic [DW-1:0]    d_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= '0;
          for (int k = 0; k < DEPTH; k++) d_q[k] <= '0;
        end else begin
          v_q[0] <= in_v;
          d_q[0] <= in_d;
          for (int k = 1; k < DEPTH; k++) begin
            v_q[k] <= v_q[k-1];
            d_q[k] <= d_q[k-1];
          end
        end
      end
      assign out_v = v_q[DEPTH-1];
      assign out_d = d_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fd_index_fifo.sv
module fd_index_fifo #(
  parameter int EW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_v,
  output logic          push_rdy,
  input  logic [EW-1:0] push_d,
  input  logic          pop,
  output logic          empty,
  output logic [EW-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_rdy = (cnt != CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign head     = mem[rd_p];
  assign do_push  = push_v && push_rdy;
  assign do_pop   = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= bump(wr_p);
      if (do_pop)  rd_p <= bump(rd_p);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/fd_gather.sv
module fd_gather #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sparse_on,
  input  logic          q_empty,
  input  logic [AW-1:0] q_aidx,
  input  logic [AW-1:0] q_bidx,
  input  logic          q_last,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  output logic          pop,
  output logic          ra_en,
  output logic [AW-1:0] ra_addr,
  output logic          rb_en,
  output logic [AW-1:0] rb_addr,
  input  logic [DW-1:0] ra_data,
  input  logic [DW-1:0] rb_data,
  output logic          sp_valid,
  output logic [DW-1:0] sp_a,
  output logic [DW-1:0] sp_b,
  output logic [AW-1:0] sp_aidx,
  output logic [AW-1:0] sp_bidx,
  output logic          sp_last
);
  logic          s_valid, s_last;
  logic [AW-1:0] s_aidx, s_bidx;

  // address generation: issue straight from the queue head
  assign pop     = sparse_on && !q_empty;
  assign ra_en   = pop;
  assign rb_en   = pop;
  assign ra_addr = a_base + q_aidx;
  assign rb_addr = b_base + q_bidx;

  // alignment stage matching the one-cycle buffer latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_last  <= 1'b0;
      s_aidx  <= '0;
      s_bidx  <= '0;
    end else if (pop) begin
      s_valid <= 1'b1;
      s_last  <= q_last;
      s_aidx  <= q_aidx;
      s_bidx  <= q_bidx;
    end else begin
      s_valid <= 1'b0;
      s_last  <= 1'b0;
      s_aidx  <= '0;
      s_bidx  <= '0;
    end
  end

  assign sp_valid = s_valid;
  assign sp_last  = s_last;
  assign sp_aidx  = s_aidx;
  assign sp_bidx  = s_bidx;
  assign sp_a     = s_valid ? ra_data : '0;
  assign sp_b     = s_valid ? rb_data : '0;
endmodule

// File: rtl/operand_feeder.sv
module operand_feeder
  import feeder_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DW     = 8,
  parameter int AW     = 6,
  parameter int QDEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                dn_valid,
  output logic                dn_ready,
  input  logic [LANES*DW-1:0] dn_data,
  output logic [LANES-1:0]    sk_valid,
  output logic [LANES*DW-1:0] sk_data,
  input  logic                iq_valid,
  output logic                iq_ready,
  input  logic [AW-1:0]       iq_aidx,
  input  logic [AW-1:0]       iq_bidx,
  input  logic                iq_last,
  input  logic [AW-1:0]       a_base,
  input  logic [AW-1:0]       b_base,
  output logic                ra_en,
  output logic [AW-1:0]       ra_addr,
  input  logic [DW-1:0]       ra_data,
  output logic                rb_en,
  output logic [AW-1:0]       rb_addr,
  input  logic [DW-1:0]       rb_data,
  output logic                sp_valid,
  output logic [DW-1:0]       sp_a,
  output logic [DW-1:0]       sp_b,
  output logic [AW-1:0]       sp_aidx,
  output logic [AW-1:0]       sp_bidx,
  output logic                sp_last
);
  localparam int EW = 2 * AW + 1;

  feed_mode_e    mode_e;
  logic          sparse_on, beat_ok;
  logic          q_empty, q_pop, q_head_last;
  logic [EW-1:0] q_head;

  assign mode_e    = feed_mode_e'(mode);
  assign sparse_on = (mode_e == FEED_SPARSE);
  assign dn_ready  = (mode_e == FEED_DENSE);
  assign beat_ok   = dn_valid && dn_ready;

  // dense path: lane i delayed by i stages
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fd_skew_lane #(.DW(DW), .DEPTH(i)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (beat_ok),
      .in_d  (dn_data[i*DW +: DW]),
      .out_v (sk_valid[i]),
      .out_d (sk_data[i*DW +: DW])
    );
  end

  // sparse path: index queue then gather
  fd_index_fifo #(.EW(EW), .DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_v   (iq_valid),
    .push_rdy (iq_ready),
    .push_d   ({iq_last, iq_bidx, iq_aidx}),
    .pop      (q_pop),
    .empty    (q_empty),
    .head     (q_head)
  );

  assign q_head_last = q_head[EW-1];

  fd_gather #(.AW(AW), .DW(DW)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .sparse_on (sparse_on),
    .q_empty   (q_empty),
    .q_aidx    (q_head[AW-1:0]),
    .q_bidx    (q_head[2*AW-1:AW]),
    .q_last    (q_head_last),
    .a_base    (a_base),
    .b_base    (b_base),
    .pop       (q_pop),
    .ra_en     (ra_en),
    .ra_addr   (ra_addr),
    .rb_en     (rb_en),
    .rb_addr   (rb_addr),
    .ra_data   (ra_data),
    .rb_data   (rb_data),
    .sp_valid  (sp_valid),
    .sp_a      (sp_a),
    .sp_b      (sp_b),
    .sp_aidx   (sp_aidx),
    .sp_bidx   (sp_bidx),
    .sp_last   (sp_last)
  );
endmodule

// File: rtl/operand_feeder_chk.sv
module operand_feeder_chk #(
  parameter int LANES = 4,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [LANES-1:0] sk_valid,
  input logic             iq_ready,
  input logic             ra_en,
  input logic [AW-1:0]    ra_addr,
  input logic [AW-1:0]    a_base,
  input logic             sp_valid,
  input logic [AW-1:0]    sp_aidx,
  input logic             sp_last,
  input logic             head_last
);
  generate
    if (LANES > 1) begin : g_skew
      assert_lane1_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sk_valid[1] == $past(dn_valid && dn_ready)));
    end
  endgenerate

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!iq_ready && !ra_en) |=> !iq_ready);

  assert_issue_then_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ra_en |=> sp_valid);

  assert_idx_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |-> (sp_aidx == AW'($past(ra_addr) - $past(a_base))));

  assert_no_valid_without_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sp_valid) |-> $past(ra_en));

  assert_last_carried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_valid |-> (sp_last == $past(head_last)));
endmodule

bind operand_feeder operand_feeder_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .sk_valid  (sk_valid),
  .iq_ready  (iq_ready),
  .ra_en     (ra_en),
  .ra_addr   (ra_addr),
  .a_base    (a_base),
  .sp_valid  (sp_valid),
  .sp_aidx   (sp_aidx),
  .sp_last   (sp_last),
  .head_last (q_head_last)
);

// File: tb/operand_feeder_bench.sv
module operand_feeder_bench;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int AW    = 6;
  localparam int QD    = 8;
  localparam int AMASK = (1 << AW) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                mode = 1'b0;
  logic                dn_valid = 1'b0;
  logic                dn_ready;
  logic [LANES*DW-1:0] dn_data = '0;
  logic [LANES-1:0]    sk_valid;
  logic [LANES*DW-1:0] sk_data;
  logic                iq_valid = 1'b0;
  logic                iq_ready;
  logic [AW-1:0]       iq_aidx = '0, iq_bidx = '0;
  logic                iq_last = 1'b0;
  logic [AW-1:0]       a_base = '0, b_base = '0;
  logic                ra_en, rb_en;
  logic [AW-1:0]       ra_addr, rb_addr;
  logic [DW-1:0]       ra_data = '0, rb_data = '0;
  logic                sp_valid, sp_last;
  logic [DW-1:0]       sp_a, sp_b;
  logic [AW-1:0]       sp_aidx, sp_bidx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  operand_feeder #(.LANES(LANES), .DW(DW), .AW(AW), .QDEPTH(QD)) u_operand_feeder (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .sk_valid(sk_valid), .sk_data(sk_data),
    .iq_valid(iq_valid), .iq_ready(iq_ready), .iq_aidx(iq_aidx), .iq_bidx(iq_bidx),
    .iq_last(iq_last), .a_base(a_base), .b_base(b_base),
    .ra_en(ra_en), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data),
    .sp_valid(sp_valid), .sp_a(sp_a), .sp_b(sp_b),
    .sp_aidx(sp_aidx), .sp_bidx(sp_bidx), .sp_last(sp_last)
  );

  function automatic logic [DW-1:0] mem_a(input logic [AW-1:0] x);
    return DW'(x * 7 + 3);
  endfunction
  function automatic logic [DW-1:0] mem_b(input logic [AW-1:0] x);
    return DW'(x) ^ 8'hA5;
  endfunction

  // buffer memories with one-cycle read latency
  always @(posedge clk) begin
    if (ra_en) ra_data <= mem_a(ra_addr);
    if (rb_en) rb_data <= mem_b(rb_addr);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  typedef struct packed {
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic          l;
  } pair_t;

  pair_t               q[$];
  logic                hv [LANES];
  logic [LANES*DW-1:0] hvec [LANES];
  logic                pend_v;
  pair_t               pend;
  logic [AW-1:0]       pa, pb;

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int k = 0; k < LANES; k++) begin hv[k] = 1'b0; hvec[k] = '0; end
      pend_v = 1'b0;
      pend = '0;
      pa = '0; pb = '0;
    end else begin
      bit room;
      room = (q.size() < QD);
      for (int k = LANES - 1; k >= 2; k--) begin hv[k] = hv[k-1]; hvec[k] = hvec[k-1]; end
      hv[1] = dn_valid && (mode == 1'b0);
      hvec[1] = dn_data;
      if (mode == 1'b1 && q.size() > 0) begin
        pend = q.pop_front();
        pend_v = 1'b1;
        pa = AW'((int'(a_base) + int'(pend.a)) & AMASK);
        pb = AW'((int'(b_base) + int'(pend.b)) & AMASK);
      end else begin
        pend_v = 1'b0;
      end
      if (iq_valid && room) q.push_back('{a: iq_aidx, b: iq_bidx, l: iq_last});
    end
    // compare with inputs still held
    for (int i = 0; i < LANES; i++) begin
      logic ev;
      logic [DW-1:0] ed;
      ev = (i == 0) ? (dn_valid && mode == 1'b0) : hv[i];
      ed = (i == 0) ? dn_data[i*DW +: DW] : hvec[i][i*DW +: DW];
      chk(sk_valid[i] == ev, "R2", $sformatf("sk_valid[%0d]", i), sk_valid[i], ev);
      if (ev) chk(sk_data[i*DW +: DW] == ed, "R2", $sformatf("sk_data[%0d]", i),
                  sk_data[i*DW +: DW], ed);
    end
    chk(dn_ready == (mode == 1'b0), "R3", "dn_ready", dn_ready, mode == 1'b0);
    chk(iq_ready == (q.size() < QD), "R4", "iq_ready", iq_ready, q.size() < QD);
    begin
      logic ee;
      ee = (mode == 1'b1) && (q.size() > 0);
      chk(ra_en == ee && rb_en == ee, "R5", "read enable", {ra_en, rb_en}, {ee, ee});
      if (ee) begin
        logic [AW-1:0] ea, eb;
        ea = AW'((int'(a_base) + int'(q[0].a)) & AMASK);
        eb = AW'((int'(b_base) + int'(q[0].b)) & AMASK);
        chk(ra_addr == ea, "R5", "ra_addr", ra_addr, ea);
        chk(rb_addr == eb, "R5", "rb_addr", rb_addr, eb);
      end
    end
    chk(sp_valid == pend_v, "R7", "sp_valid", sp_valid, pend_v);
    chk(sp_a == (pend_v ? mem_a(pa) : '0), "R6", "sp_a", sp_a, pend_v ? mem_a(pa) : '0);
    chk(sp_b == (pend_v ? mem_b(pb) : '0), "R6", "sp_b", sp_b, pend_v ? mem_b(pb) : '0);
    chk(sp_aidx == (pend_v ? pend.a : '0), "R6", "sp_aidx", sp_aidx, pend_v ? pend.a : '0);
    chk(sp_bidx == (pend_v ? pend.b : '0), "R6", "sp_bidx", sp_bidx, pend_v ? pend.b : '0);
    chk(sp_last == (pend_v && pend.l), "R8", "sp_last", sp_last, pend_v && pend.l);
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic push(input int a, input int b, input bit l);
    iq_valid = 1'b1;
    iq_aidx = AW'(a);
    iq_bidx = AW'(b);
    iq_last = l;
    tick();
    iq_valid = 1'b0;
  endtask

  initial begin
    int first, last, cnt;
    repeat (3) tick();
    chk(sk_valid == '0, "R1", "sk_valid in reset", sk_valid, 0);
    chk(sp_valid == 1'b0, "R1", "sp_valid in reset", sp_valid, 0);
    chk(iq_ready == 1'b1, "R1", "iq_ready in reset", iq_ready, 1);
    rst_n = 1'b1;
    tick();
    chk(sk_valid == '0 && sp_valid == 1'b0, "R1", "idle after reset", {sk_valid, sp_valid}, 0);

    // dense wavefront with gaps (R2)
    mode = 1'b0;
    for (int n = 0; n < 12; n++) begin
      dn_valid = (n % 3 != 2);
      dn_data = {8'(n * 17 + 1), 8'(n * 5 + 2), 8'(n + 40), 8'(255 - n)};
      tick();
    end
    dn_valid = 1'b0;
    repeat (LANES + 1) tick();

    // entries held while dense (R9)
    push(1, 2, 1'b0);
    push(3, 4, 1'b0);
    push(5, 6, 1'b1);
    repeat (3) tick();
    chk(sp_valid == 1'b0 && ra_en == 1'b0, "R9", "no issue in dense mode",
        {sp_valid, ra_en}, 0);
    mode = 1'b1;
    repeat (5) tick();

    // fill past full (R4), burst (R10)
    mode = 1'b0;
    for (int n = 0; n < QD + 2; n++) push(n + 8, 40 - n, n == QD - 1);
    chk(iq_ready == 1'b0, "R4", "iq_ready when full", iq_ready, 0);
    mode = 1'b1;
    first = -1; last = -1; cnt = 0;
    for (int c = 0; c < QD + 4; c++) begin
      tick();
      if (sp_valid) begin
        cnt++;
        if (first < 0) first = c;
        last = c;
      end
    end
    chk(cnt == QD, "R10", "burst beat count", cnt, QD);
    chk(last - first + 1 == QD, "R10", "burst span", last - first + 1, QD);

    // dense beats ignored in sparse mode (R3)
    dn_valid = 1'b1;
    dn_data = 32'hDEADBEEF;
    tick();
    dn_valid = 1'b0;
    for (int c = 0; c < LANES; c++) begin
      chk(sk_valid == '0, "R3", "sk_valid after ignored beat", sk_valid, 0);
      tick();
    end

    // streaming push and pop with wrap-around (R5, R6, R8)
    a_base = AW'(60);
    b_base = AW'(50);
    for (int n = 0; n < 6; n++) push(n * 9 + 10, n * 11 + 20, n == 5);
    repeat (3) tick();

    // switch to dense while pairs pending, then back
    for (int n = 0; n < 4; n++) push(n, n + 1, n == 3);
    mode = 1'b0;
    dn_valid = 1'b1;
    dn_data = 32'h01020304;
    tick();
    dn_valid = 1'b0;
    repeat (2) tick();
    mode = 1'b1;
    repeat (8) tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule